// File: doc/BRIEF.md
# Per-Master Grant Flag Bank with One-Shot Notification

This block records which semaphore resources have been handed to each bus master through a queued or posted request. It keeps a flag word for every master, with one bit for each resource. It also drives one grant notification line per master. A semaphore engine sends it grant events. Software reads the words and clears them through a small register port.

Each notification line is a one-shot. It pulses once when its master's flag word holds at least one set bit. After that it stays quiet until software re-arms it by writing that master's select code to a shared end-of-interrupt register. Flags that arrive while a line is quiet are kept. If any bit is still set when the line is re-armed, the line pulses again at once. A write-only set register per master lets software inject flag bits directly.

Grant events arrive on a valid/ready channel. An event is taken on every clock edge where `gnt_valid` and `gnt_ready` are both high. The block applies no back-pressure: `gnt_ready` stays high, so the engine never has to hold an event. The register port is a single-cycle request interface. A write takes effect at the edge that samples it. A read returns its answer in the following cycle.

Top module: `sem_grant_notify`

## Requirements
- R1: After reset every flag word reads zero, every notification line is low and every line is armed, so the first flag bit that sets afterwards produces a pulse.
- R2: An accepted grant event with `gnt_notify`=1 sets bit `gnt_res` of the word of master `gnt_master`. An event with `gnt_notify`=0 changes no flag and causes no pulse.
- R3: A write to the flag word of master m (address 0x400 + 4*m) clears each bit where the write data holds a 1. Bits where the write data holds a 0 keep their value.
- R4: A write to the set register of master m (address 0x480 + 4*m) sets each flag bit where the write data holds a 1. A read of a set register returns zero without an error.
- R5: When master m's line is armed and its flag word after a clock edge is nonzero, `irq[m]` is high for exactly the one cycle after that edge, and the line becomes disarmed.
- R6: While a line is disarmed, newly set flags do not raise it, and the flags are kept.
- R7: A write to address 0x00C whose data bits [7:0] equal m re-arms line m. If master m's word is nonzero at that point, the line pulses in the next cycle. Any other select value re-arms nothing.
- R8: A read of address 0x00C returns `bus_rerr`=1 with `bus_rdata` zero.
- R9: Every read gets `bus_rvalid` high in exactly the next cycle, and no other cycle has `bus_rvalid` high. A read of a flag word returns its value before that edge. A read of an unmapped address returns zero with no error.
- R10: `gnt_ready` is always high. If a grant event sets a bit in the same cycle that a clear write hits the same bit, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gnt_valid | input | 1 | Grant event valid |
| gnt_ready | output | 1 | Grant event accepted (always high) |
| gnt_notify | input | 1 | Event qualifies for flag and notification |
| gnt_master | input | 2 | Master receiving the grant |
| gnt_res | input | 5 | Resource index granted |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read response valid |
| bus_rdata | output | 32 | Read response data |
| bus_rerr | output | 1 | Read response error |
| irq | output | 3 | One-shot grant notification per master |

## Verification
The hardest situation to reach is a re-arm that lands while flags are still pending, or that lands in the same cycle as a fresh grant or a clear of the last bit. Only then can the immediate second pulse, or the lack of one, be seen. The stimulus first walks through these cases directly. It then runs a long random mix in which end-of-interrupt writes, clear writes and grant events often share a cycle. All three masters and the full set of select codes are drawn at random, so pending-flag re-arms occur many times. A bench model predicts every pulse and every read response.

// File: rtl/sem_flag_pkg.sv
package sem_flag_pkg;
  localparam int unsigned DEF_MASTERS = 3;
  localparam int unsigned DEF_RES     = 32;
  localparam int unsigned DEF_ADDR_W  = 12;
  localparam int unsigned DEF_DATA_W  = 32;
  localparam int unsigned EOI_OFS     = 32'h00C;
  localparam int unsigned FLAG_OFS    = 32'h400;
  localparam int unsigned SET_OFS     = 32'h480;
  localparam int unsigned WORD_STRIDE = 4;

  typedef struct packed {
    logic valid;
    logic err;
  } rd_status_t;
endpackage

// File: rtl/sem_flag_regif.sv
module sem_flag_regif
  import sem_flag_pkg::*;
#(
  parameter int unsigned NM = DEF_MASTERS,
  parameter int unsigned NR = DEF_RES,
  parameter int unsigned AW = DEF_ADDR_W,
  parameter int unsigned DW = DEF_DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_req,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  input  logic [NM*NR-1:0] flags_flat,
  output logic [NM*NR-1:0] clr_flat,
  output logic [NM*NR-1:0] set_flat,
  output logic [NM-1:0]    rearm,
  output logic             bus_rvalid,
  output logic [DW-1:0]    bus_rdata,
  output logic             bus_rerr
);
  localparam logic [AW-1:0] EOI_A = AW'(EOI_OFS);

  logic [NM-1:0] hit_flag, hit_set;
  logic          wr, rd;
  logic          hit_eoi;
  logic [DW-1:0] rd_next;
  rd_status_t    st_q;

  assign wr      = bus_req & bus_we;
  assign rd      = bus_req & ~bus_we;
  assign hit_eoi = (bus_addr == EOI_A);

  for (genvar m = 0; m < NM; m++) begin : g_dec
    localparam logic [AW-1:0] FA = AW'(FLAG_OFS + WORD_STRIDE * m);
    localparam logic [AW-1:0] SA = AW'(SET_OFS + WORD_STRIDE * m);
    assign hit_flag[m] = (bus_addr == FA);
    assign hit_set[m]  = (bus_addr == SA);
    assign clr_flat[m*NR +: NR] = (wr && hit_flag[m]) ? bus_wdata[NR-1:0] : '0;
    assign set_flat[m*NR +: NR] = (wr && hit_set[m])  ? bus_wdata[NR-1:0] : '0;
    assign rearm[m] = wr && hit_eoi && (bus_wdata[7:0] == 8'(m));
  end

  always_comb begin
    rd_next = '0;
    for (int m = 0; m < NM; m++) begin
      if (hit_flag[m]) rd_next = DW'(flags_flat[m*NR +: NR]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= '0;
      bus_rdata <= '0;
    end else begin
      st_q.valid <= rd;
      st_q.err   <= rd && hit_eoi;
      bus_rdata  <= (rd && !hit_eoi) ? rd_next : '0;
    end
  end

  assign bus_rvalid = st_q.valid;
  assign bus_rerr   = st_q.err;
endmodule

// File: rtl/sem_flag_word.sv
module sem_flag_word #(
  parameter int unsigned NR = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NR-1:0] clr,
  input  logic [NR-1:0] set_bus,
  input  logic [NR-1:0] set_gnt,
  output logic [NR-1:0] word_q,
  output logic          any_next
);
  logic [NR-1:0] word_n;

  // a grant in the same cycle as a clear wins: the event is newer
  assign word_n   = (word_q & ~clr) | set_bus | set_gnt;
  assign any_next = |word_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_n;
  end
endmodule

// File: rtl/sem_flag_line.sv
module sem_flag_line (
  input  logic clk,
  input  logic rst_n,
  input  logic rearm,
  input  logic any_next,
  output logic irq_q
);
  logic armed_q, arm_eff, fire;

  assign arm_eff = armed_q | rearm;
  assign fire    = arm_eff & any_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      armed_q <= arm_eff & ~fire;
      irq_q   <= fire;
    end
  end
endmodule

// File: rtl/sem_grant_notify.sv
module sem_grant_notify
  import sem_flag_pkg::*;
#(
  parameter int unsigned NUM_MASTERS = DEF_MASTERS,
  parameter int unsigned NUM_RES     = DEF_RES,
  parameter int unsigned ADDR_W      = DEF_ADDR_W,
  parameter int unsigned DATA_W      = DEF_DATA_W,
  localparam int unsigned MW = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1,
  localparam int unsigned RW = (NUM_RES > 1) ? $clog2(NUM_RES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   gnt_valid,
  output logic                   gnt_ready,
  input  logic                   gnt_notify,
  input  logic [MW-1:0]          gnt_master,
  input  logic [RW-1:0]          gnt_res,
  input  logic                   bus_req,
  input  logic                   bus_we,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic                   bus_rvalid,
  output logic [DATA_W-1:0]      bus_rdata,
  output logic                   bus_rerr,
  output logic [NUM_MASTERS-1:0] irq
);
  localparam int unsigned NF = NUM_MASTERS * NUM_RES;

  logic [NF-1:0]          flags_flat, clr_flat, set_flat;
  logic [NUM_MASTERS-1:0] rearm, any_next;
  logic                   gnt_take;
  logic [NUM_RES-1:0]     gnt_onehot;

  assign gnt_ready  = 1'b1;
  assign gnt_take   = gnt_valid & gnt_ready & gnt_notify;
  assign gnt_onehot = NUM_RES'(1) << gnt_res;

  sem_flag_regif #(
    .NM(NUM_MASTERS), .NR(NUM_RES), .AW(ADDR_W), .DW(DATA_W)
  ) u_regif (
    .clk(clk), .rst_n(rst_n),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .flags_flat(flags_flat), .clr_flat(clr_flat), .set_flat(set_flat), .rearm(rearm),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .bus_rerr(bus_rerr)
  );

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_master
    logic [NUM_RES-1:0] set_gnt;
    assign set_gnt = (gnt_take && gnt_master == MW'(m)) ? gnt_onehot : '0;

    sem_flag_word #(.NR(NUM_RES)) u_word (
      .clk(clk), .rst_n(rst_n),
      .clr(clr_flat[m*NUM_RES +: NUM_RES]),
      .set_bus(set_flat[m*NUM_RES +: NUM_RES]),
      .set_gnt(set_gnt),
      .word_q(flags_flat[m*NUM_RES +: NUM_RES]),
      .any_next(any_next[m])
    );

    sem_flag_line u_line (
      .clk(clk), .rst_n(rst_n),
      .rearm(rearm[m]), .any_next(any_next[m]), .irq_q(irq[m])
    );
  end
endmodule

// File: rtl/sem_grant_notify_chk.sv
module sem_grant_notify_chk
  import sem_flag_pkg::*;
#(
  parameter int unsigned NM = DEF_MASTERS,
  parameter int unsigned NR = DEF_RES,
  parameter int unsigned AW = DEF_ADDR_W,
  parameter int unsigned DW = DEF_DATA_W,
  parameter int unsigned MW = 2,
  parameter int unsigned RW = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gnt_valid,
  input logic             gnt_notify,
  input logic [MW-1:0]    gnt_master,
  input logic [RW-1:0]    gnt_res,
  input logic             bus_req,
  input logic             bus_we,
  input logic [AW-1:0]    bus_addr,
  input logic [DW-1:0]    bus_wdata,
  input logic             bus_rvalid,
  input logic             bus_rerr,
  input logic [NM-1:0]    irq,
  input logic [NM*NR-1:0] flags_flat
);
  localparam logic [AW-1:0] EOI_A = AW'(EOI_OFS);

  a_r9_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we) |=> bus_rvalid);
  a_r9_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && !bus_we) |=> !bus_rvalid);
  a_r8_eoi_read_err: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && bus_addr == EOI_A) |=> bus_rerr);

  for (genvar m = 0; m < NM; m++) begin : g_m
    a_r5_pulse_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq[m] |-> (|flags_flat[m*NR +: NR]));
    a_r6_no_refire_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[m] && !(bus_req && bus_we && bus_addr == EOI_A && bus_wdata[7:0] == 8'(m)))
      |=> !irq[m]);
    a_r2_grant_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_valid && gnt_notify && gnt_master == MW'(m))
      |=> flags_flat[m*NR + int'($past(gnt_res))]);
  end
endmodule

bind sem_grant_notify sem_grant_notify_chk #(
  .NM(NUM_MASTERS), .NR(NUM_RES), .AW(ADDR_W), .DW(DATA_W), .MW(MW), .RW(RW)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .gnt_valid(gnt_valid), .gnt_notify(gnt_notify), .gnt_master(gnt_master), .gnt_res(gnt_res),
  .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rvalid(bus_rvalid), .bus_rerr(bus_rerr), .irq(irq), .flags_flat(flags_flat)
);

// File: tb/tb_sem_grant_notify.sv
module tb_sem_grant_notify;
  localparam int NM = 3;
  localparam logic [11:0] EOI  = 12'h00C;
  localparam logic [11:0] FLAG = 12'h400;
  localparam logic [11:0] SETR = 12'h480;

  logic        clk = 0, rst_n = 0;
  logic        gnt_valid = 0, gnt_notify = 0, gnt_ready;
  logic [1:0]  gnt_master = 0;
  logic [4:0]  gnt_res = 0;
  logic        bus_req = 0, bus_we = 0;
  logic [11:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        bus_rvalid, bus_rerr;
  logic [2:0]  irq;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] m_flags [NM];
  bit          m_armed [NM];

  always #4 clk = ~clk;

  sem_grant_notify dut (
    .clk(clk), .rst_n(rst_n), .gnt_valid(gnt_valid), .gnt_ready(gnt_ready),
    .gnt_notify(gnt_notify), .gnt_master(gnt_master), .gnt_res(gnt_res),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .bus_rerr(bus_rerr), .irq(irq)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(logic [11:0] a);
    for (int m = 0; m < NM; m++) if (a == FLAG + 12'(4*m)) return m_flags[m];
    return 32'h0;
  endfunction

  // one cycle of stimulus; model update and checks after the edge
  task automatic step(bit g, bit gn, logic [1:0] gm, logic [4:0] gr,
                      bit b, bit w, logic [11:0] a, logic [31:0] d, string tag);
    logic [2:0]  e_irq;
    logic [31:0] e_rd;
    bit          is_rd;
    @(negedge clk);
    gnt_valid = g; gnt_notify = gn; gnt_master = gm; gnt_res = gr;
    bus_req = b; bus_we = w; bus_addr = a; bus_wdata = d;
    is_rd = b && !w;
    e_rd  = (is_rd && a != EOI) ? exp_read(a) : 32'h0;
    for (int m = 0; m < NM; m++) begin
      logic [31:0] clr, st, nf;
      bit ra, arm;
      clr = (b && w && a == FLAG + 12'(4*m)) ? d : 32'h0;
      st  = (b && w && a == SETR + 12'(4*m)) ? d : 32'h0;
      if (g && gn && gm == 2'(m)) st |= (32'h1 << gr);
      nf  = (m_flags[m] & ~clr) | st;
      ra  = b && w && a == EOI && d[7:0] == 8'(m);
      arm = m_armed[m] | ra;
      e_irq[m]   = arm && (nf != 0);
      m_armed[m] = arm && !(nf != 0);
      m_flags[m] = nf;
    end
    @(posedge clk); #1;
    gnt_valid = 0; bus_req = 0;
    chk(irq == e_irq, {tag, " irq (R5/R6/R7)"}, 32'(irq), 32'(e_irq));
    chk(bus_rvalid == is_rd, "R9 rvalid", 32'(bus_rvalid), 32'(is_rd));
    if (is_rd) begin
      chk(bus_rdata == e_rd, {tag, " rdata"}, bus_rdata, e_rd);
      chk(bus_rerr == (a == EOI), "R8 rerr", 32'(bus_rerr), 32'(a == EOI));
    end
  endtask

  task automatic rd(logic [11:0] a, string tag);
    step(0, 0, 0, 0, 1, 0, a, 0, tag);
  endtask
  task automatic wr(logic [11:0] a, logic [31:0] d, string tag);
    step(0, 0, 0, 0, 1, 1, a, d, tag);
  endtask
  task automatic gnt(bit n, logic [1:0] m, logic [4:0] r, string tag);
    step(1, n, m, r, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int m = 0; m < NM; m++) begin m_flags[m] = 0; m_armed[m] = 1; end
    repeat (3) @(posedge clk);
    #1;
    chk(irq == 3'b000, "R1 irq low in reset", 32'(irq), 0);
    @(negedge clk); rst_n = 1;
    for (int m = 0; m < NM; m++) rd(FLAG + 12'(4*m), "R1 flags zero");
    chk(gnt_ready == 1'b1, "R10 ready high", 32'(gnt_ready), 1);

    gnt(0, 0, 3, "R2 non-notify ignored");
    rd(FLAG, "R2 non-notify no flag");
    gnt(1, 1, 7, "R1 first grant fires");
    rd(FLAG + 4, "R2 flag set");
    gnt(1, 1, 9, "R6 disarmed silent");
    rd(FLAG + 4, "R6 flags kept");
    wr(FLAG + 4, 32'h0000_0080, "R3 w1c");
    rd(FLAG + 4, "R3 zero bits kept");
    wr(EOI, 32'h1, "R7 rearm pending refires");
    wr(FLAG + 4, 32'hFFFF_FFFF, "R3 clear all");
    wr(EOI, 32'h1, "R7 rearm empty quiet");
    wr(EOI, 32'h5, "R7 bad select");
    gnt(1, 1, 0, "R7 armed again fires");
    wr(SETR + 8, 32'h0000_00F0, "R4 set inject fires");
    rd(FLAG + 8, "R4 set visible");
    rd(SETR + 8, "R4 set reads zero");
    rd(EOI, "R8 eoi read error");
    rd(12'h010, "R9 unmapped read");
    step(1, 1, 0, 4, 1, 1, FLAG, 32'h0000_0010, "R10 grant beats clear");
    rd(FLAG, "R10 bit survives");
    step(1, 1, 2, 31, 1, 1, EOI, 32'h2, "R7 rearm with grant");
    chk(gnt_ready == 1'b1, "R10 ready still high", 32'(gnt_ready), 1);

    for (int i = 0; i < 1500; i++) begin
      int k;
      logic [1:0] m;
      m = 2'($urandom_range(0, NM - 1));
      k = $urandom_range(0, 5);
      case (k)
        0: step($urandom_range(0,1), $urandom_range(0,3) != 0, m, 5'($urandom), 0, 0, 0, 0, "R2 rnd grant");
        1: step($urandom_range(0,1), 1, m, 5'($urandom), 1, 0, FLAG + 12'(4*m), 0, "R9 rnd read");
        2: step($urandom_range(0,1), 1, m, 5'($urandom), 1, 1, FLAG + 12'(4*m), $urandom, "R3 rnd clear");
        3: step($urandom_range(0,1), 1, m, 5'($urandom), 1, 1, SETR + 12'(4*m), $urandom & $urandom & $urandom, "R4 rnd set");
        4: step($urandom_range(0,1), 1, m, 5'($urandom), 1, 1, EOI, 32'($urandom_range(0,4)), "R7 rnd eoi");
        default: step(0, 0, 0, 0, 1, 0, EOI, 0, "R8 rnd eoi read");
      endcase
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule